// File: doc/BRIEF.md
# Phase-Offset PWM Duty Controller

This block produces a fixed-frequency pulse-width-modulated output from a single set/reset flop. Two free-running counters with the same length drive the flop. The set counter's wrap pulse raises the output and the reset counter's wrap pulse lowers it. No compare register stores the duty cycle. The duty cycle is the phase distance between the two counters, so it stays constant for as long as nothing disturbs either counter.

A held increase or decrease request moves that distance by one clock cycle each time an adjustment timer expires. The move is made by stalling one of the counters for a single cycle. Coincident wrap pulses mark the point where the distance has reached 0% or 100%. The output level at that moment tells the two apart, and a latch then pins the output and blocks further movement in that direction. After reset the counters are frozen at 0% until the first accepted increase.

Top module: `pwm_phase_duty`

## Requirements
- R1: After reset `pwm_o` is 0, `at_min_o` is 1 and `at_max_o` is 0. The counters stay frozen, and a decrease request changes nothing, until the first increase request is accepted.
- R2: The output repeats every `PERIOD` clock cycles. With a phase distance of d steps (0..`PERIOD`), it is high for exactly d of every `PERIOD` consecutive cycles.
- R3: While only the increase input is held, and 100% has not been reached, d rises by one at the end of every `ADJ_DIV` consecutive cycles of the hold.
- R4: While only the decrease input is held, and 0% has not been reached, d falls by one at the end of every `ADJ_DIV` consecutive cycles of the hold.
- R5: The adjustment timer clears whenever no request is accepted. A request held for fewer than `ADJ_DIV` cycles has no effect, and two short holds do not add up.
- R6: With no request active, the duty cycle does not change.
- R7: When increase and decrease are asserted together, both are ignored.
- R8: At d = `PERIOD`, `at_max_o` rises, `pwm_o` stays high, and further increases are ignored. One decrease step clears `at_max_o` and gives d = `PERIOD`-1.
- R9: At d = 0 while running, `at_min_o` rises, `pwm_o` stays low, and further decreases are ignored. One increase step clears `at_min_o` and gives d = 1.
- R10: `at_min_o` and `at_max_o` are never high together. `ADJ_DIV` must be at least 2*`PERIOD`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; one phase step is one cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Increase-duty request, level sensitive |
| dec_i | input | 1 | Decrease-duty request, level sensitive |
| pwm_o | output | 1 | PWM output |
| at_min_o | output | 1 | High while the duty cycle is 0% |
| at_max_o | output | 1 | High while the duty cycle is 100% |

## Verification
The hardest state to reach is the step into 100%. In that state the counters wrap together exactly as they do at 0%, so only the flop level at the coincidence tells the limits apart. The latch must also close before the next timer expiry can push the distance past the limit. The stimulus holds the increase input for many more timer intervals than the remaining steps need. It then checks that the output is high in every cycle and that a long extra hold still changes nothing. The descent to 0% is driven the same way, followed by a single step out of each limit.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    // Request accepted by the adjustment timer in the current cycle.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_UP   = 2'd1,
        REQ_DOWN = 2'd2
    } req_e;

    // Registered state of the output flop and the limit tracker.
    typedef struct packed {
        logic run;     // counters released
        logic at_min;  // 0% latch
        logic at_max;  // 100% latch
        logic level;   // set/reset flop
    } lim_state_t;

endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
    parameter int unsigned PERIOD = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic stall_i,
    output logic tick_o
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          adv;

    always_comb begin
        adv   = run_i & ~stall_i;
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
        tick_o = adv && (cnt_q == LAST);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // A stalled counter keeps its phase for that cycle (basis of R3/R4 stepping).
    assert_stall_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i || !run_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_adj_timer.sv
module pwm_adj_timer
    import pwm_phase_pkg::*;
#(
    parameter int unsigned ADJ_DIV = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    input  logic min_i,
    input  logic max_i,
    output req_e req_o,
    output logic step_o
);
    localparam int unsigned CW = (ADJ_DIV > 1) ? $clog2(ADJ_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(ADJ_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        req_o = REQ_NONE;
        if (inc_i && !dec_i && !max_i)      req_o = REQ_UP;
        else if (dec_i && !inc_i && !min_i) req_o = REQ_DOWN;

        if (req_o == REQ_NONE) cnt_d = '0;
        else                   cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

        step_o = (req_o != REQ_NONE) && (cnt_q == LAST);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R7: simultaneous requests never produce a step.
    assert_both_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && dec_i) |-> !step_o);

    // R5: the timer restarts from zero once no request is accepted.
    assert_timer_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !dec_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_limit_track.sv
module pwm_limit_track
    import pwm_phase_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic set_tick_i,
    input  logic clr_tick_i,
    input  logic up_step_i,
    input  logic down_step_i,
    output logic run_o,
    output logic at_min_o,
    output logic at_max_o,
    output logic pwm_o
);
    lim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) st_d.run = 1'b1;

        if (set_tick_i && !clr_tick_i)      st_d.level = 1'b1;
        else if (clr_tick_i && !set_tick_i) st_d.level = 1'b0;

        // Coincident wraps: the held level says which limit was reached.
        if (set_tick_i && clr_tick_i) begin
            if (st_q.level) st_d.at_max = 1'b1;
            else            st_d.at_min = 1'b1;
        end

        if (up_step_i)   st_d.at_min = 1'b0;
        if (down_step_i) st_d.at_max = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{run: 1'b0, at_min: 1'b1, at_max: 1'b0, level: 1'b0};
        else         st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign at_min_o = st_q.at_min;
    assign at_max_o = st_q.at_max;
    assign pwm_o    = st_q.at_max | (st_q.level & ~st_q.at_min);

    // R8: the flop itself is high whenever the maximum latch is set.
    assert_max_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.at_max |-> st_q.level);

    // R9: the flop itself is low whenever the minimum latch is set.
    assert_min_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.at_min |-> !st_q.level);

    // R8: the maximum latch only drops after a decrease step.
    assert_max_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.at_max) |-> $past(down_step_i));

    // R9: the minimum latch only drops after an increase step.
    assert_min_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.at_min) |-> $past(up_step_i));

    // R10: the two limit flags are exclusive.
    assert_flags_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.at_min && st_q.at_max));

endmodule

// File: rtl/pwm_phase_duty.sv
module pwm_phase_duty
    import pwm_phase_pkg::*;
#(
    parameter int unsigned PERIOD  = 8,
    parameter int unsigned ADJ_DIV = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    output logic pwm_o,
    output logic at_min_o,
    output logic at_max_o
);
    // Latches must close before a further step can overshoot a limit.
    if (ADJ_DIV < 2 * PERIOD) begin : g_bad_cfg
        $error("ADJ_DIV must be at least twice PERIOD");
    end

    req_e req;
    logic step, up_step, down_step;
    logic run, set_tick, clr_tick;
    logic at_min, at_max;

    pwm_adj_timer #(.ADJ_DIV(ADJ_DIV)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc_i),
        .dec_i  (dec_i),
        .min_i  (at_min),
        .max_i  (at_max),
        .req_o  (req),
        .step_o (step)
    );

    assign up_step   = step && (req == REQ_UP);
    assign down_step = step && (req == REQ_DOWN);

    // Increase: stall the reset counter (distance grows).
    // Decrease: stall the set counter (distance shrinks).
    pwm_phase_ctr #(.PERIOD(PERIOD)) u_set_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .stall_i (down_step),
        .tick_o  (set_tick)
    );

    pwm_phase_ctr #(.PERIOD(PERIOD)) u_clr_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .stall_i (up_step),
        .tick_o  (clr_tick)
    );

    pwm_limit_track u_limits (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (req == REQ_UP),
        .set_tick_i  (set_tick),
        .clr_tick_i  (clr_tick),
        .up_step_i   (up_step),
        .down_step_i (down_step),
        .run_o       (run),
        .at_min_o    (at_min),
        .at_max_o    (at_max),
        .pwm_o       (pwm_o)
    );

    assign at_min_o = at_min;
    assign at_max_o = at_max;

    // R1: frozen counters emit no wrap pulses.
    assert_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |-> (!set_tick && !clr_tick));

    // R8: no increase step is taken while at 100%.
    assert_no_up_at_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_max_o |-> !up_step);

    // R9: no decrease step is taken while at 0%.
    assert_no_down_at_min_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_min_o |-> !down_step);

endmodule

// File: tb/test_pwm_phase_duty.sv
module test_pwm_phase_duty;
    localparam int unsigned PERIOD  = 8;
    localparam int unsigned ADJ_DIV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inc = 1'b0;
    logic dec = 1'b0;
    logic pwm, at_min, at_max;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_phase_duty #(.PERIOD(PERIOD), .ADJ_DIV(ADJ_DIV)) i_pwm_phase_duty (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .inc_i    (inc),
        .dec_i    (dec),
        .pwm_o    (pwm),
        .at_min_o (at_min),
        .at_max_o (at_max)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hold(input logic up, input logic down, input int n);
        inc = up;
        dec = down;
        cycles(n);
        inc = 1'b0;
        dec = 1'b0;
    endtask

    task automatic duty(output int highs);
        highs = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
    endtask

    task automatic expect_state(input string req, input int d, input int mn, input int mx);
        int h1, h2;
        cycles(3 * PERIOD);
        duty(h1);
        duty(h2);
        check_eq(req, "high cycles per period", h1, d);
        check_eq(req, "repeat in next period (R2)", h2, h1);
        check_eq(req, "at_min", int'(at_min), mn);
        check_eq(req, "at_max", int'(at_max), mx);
    endtask

    task automatic t_reset();
        check_eq("R1", "pwm after reset", int'(pwm), 0);
        check_eq("R1", "at_min after reset", int'(at_min), 1);
        check_eq("R1", "at_max after reset", int'(at_max), 0);
    endtask

    task automatic t_dec_before_start();
        hold(1'b0, 1'b1, 3 * ADJ_DIV);
        expect_state("R1", 0, 1, 0);
    endtask

    task automatic t_inc_steps();
        hold(1'b1, 1'b0, 3 * ADJ_DIV);
        expect_state("R3", 3, 0, 0);
    endtask

    task automatic t_idle();
        cycles(5 * ADJ_DIV);
        expect_state("R6", 3, 0, 0);
    endtask

    task automatic t_both();
        hold(1'b1, 1'b1, 3 * ADJ_DIV);
        expect_state("R7", 3, 0, 0);
    endtask

    task automatic t_short();
        hold(1'b1, 1'b0, ADJ_DIV - 1);
        cycles(1);
        hold(1'b1, 1'b0, ADJ_DIV - 1);
        expect_state("R5", 3, 0, 0);
    endtask

    task automatic t_dec_step();
        hold(1'b0, 1'b1, ADJ_DIV);
        expect_state("R4", 2, 0, 0);
    endtask

    task automatic t_to_max();
        hold(1'b1, 1'b0, 10 * ADJ_DIV);
        expect_state("R8", PERIOD, 0, 1);
        hold(1'b1, 1'b0, 3 * ADJ_DIV);
        expect_state("R8", PERIOD, 0, 1);
    endtask

    task automatic t_leave_max();
        hold(1'b0, 1'b1, ADJ_DIV);
        expect_state("R8", PERIOD - 1, 0, 0);
    endtask

    task automatic t_to_min();
        hold(1'b0, 1'b1, 12 * ADJ_DIV);
        expect_state("R9", 0, 1, 0);
        hold(1'b0, 1'b1, 3 * ADJ_DIV);
        expect_state("R9", 0, 1, 0);
    endtask

    task automatic t_leave_min();
        hold(1'b1, 1'b0, ADJ_DIV);
        expect_state("R9", 1, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_dec_before_start();
        t_inc_steps();
        t_idle();
        t_both();
        t_short();
        t_dec_step();
        t_to_max();
        t_leave_max();
        t_to_min();
        t_leave_min();
        summary();
    end

    initial begin
        cycles(20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule